// File: doc/BRIEF.md
# Dual-Lane Serial Sample Transmitter

This block sends two channel samples at a time, one per data lane, to a downstream signal processor. The block is the master of the link. It makes the bit clock by dividing the system clock, and it drives a one-period frame marker. Both lanes run from that one clock, that one marker and one set of settings, so the two lanes always move in lockstep.

A parallel stage above the block presents a pair of two's complement words with a one-cycle strobe. The block captures the pair into a one-deep holding register. On the next bit-clock rising edge it raises the frame marker, and on the rising edge after that it begins to shift both words out, most significant bit first. A pair that arrives while a frame is still running waits in the holding register. It starts a new frame on the rising edge that follows the last bit of the current frame. A further pair that arrives while the holding register is still full is dropped, and the block flags it as an overrun.

The divider setting and the word-length select are shared by both lanes. A master enable gates the whole port.

Top module: `dual_sport_tx`

## Requirements
- R1: Each lane sends its word as two's complement, most significant bit first, and both lanes send their bits on the same bit-clock edges. In 16-bit mode a lane sends bits [15:0] of its 24-bit input word, and input bits [23:16] have no effect.
- R2: `wlen_sel` = 0 gives frames of 16 data bits and `wlen_sel` = 1 gives frames of 24 data bits. The value is sampled on the edge where a frame starts.
- R3: With `div_sel` = D, one `sclk` period is D+1 system cycles, and `sclk` is high for ceil((D+1)/2) of them. With D = 0, `sclk` is held high and every system clock edge counts as a bit-clock rising edge.
- R4: A load is captured on the system edge where `load` is sampled high. `sdfs` then rises on the first bit-clock rising edge after that capture edge.
- R5: `sdfs` stays high for exactly one `sclk` period. The MSB of each lane appears on the bit-clock rising edge that ends that period.
- R6: While the port is enabled, `sdfs` and `sdo` change only on bit-clock rising edges.
- R7: With `master_en` low, `sclk`, `sdfs` and `sdo` are held low from the next system edge onward. Loads are discarded, and a frame in progress is abandoned.
- R8: A load accepted during a frame is held. Its frame marker rises on the bit-clock edge right after the last data bit, so the markers of back-to-back frames are word length + 1 bit periods apart.
- R9: A load that arrives while the holding register is full, and is not being emptied on that edge, is dropped. `overrun` is then high for one system cycle.
- R10: Between frames `sdo` is low on both lanes, and `sclk` keeps running.
- R11: During and just after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Enables clock generation and framing |
| div_sel | input | 3 | Bit-clock divide setting, ratio = value + 1 |
| wlen_sel | input | 1 | 0: 16-bit words, 1: 24-bit words |
| load | input | 1 | One-cycle strobe that presents a new word pair |
| load_data | input | 48 | Lane 0 word in [23:0], lane 1 word in [47:24] |
| sclk | output | 1 | Generated bit clock |
| sdfs | output | 1 | Frame marker, one bit period wide |
| sdo | output | 2 | Serial data, one bit per lane |
| overrun | output | 1 | One-cycle pulse when a load is dropped |

## Verification
The properties assume that `div_sel` and `wlen_sel` stay fixed while a frame is in flight, and that `load` is a synchronous strobe. The stimulus changes the divider and the word length only after the previous frame has been received in full and the link is idle. It raises `load` for exactly one system cycle. It toggles `master_en` only between negative clock edges, so that a disable is seen as a clean event. The overrun case is built by placing two strobes inside one long frame. This makes the holding register full when the second strobe arrives.

// File: rtl/dsport_pkg.sv
package dsport_pkg;
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SYNC  = 2'd1,
        FR_SHIFT = 2'd2
    } fr_state_e;
endpackage

// File: rtl/sport_sclk_div.sv
module sport_sclk_div #(
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            sclk,
    output logic            tick
);
    typedef struct packed {
        logic [DIVW-1:0] cnt;
        logic            sclk;
    } div_t;

    div_t s_q, s_d;
    logic [DIVW:0] half;

    // The high phase is ceil(ratio/2) cycles, where ratio = div + 1.
    assign half = ({1'b0, div} + (DIVW+1)'(2)) >> 1;
    assign tick = run && (s_q.cnt >= div);

    always_comb begin
        s_d = s_q;
        if (!run) begin
            // Park on the last count, so that the first enabled edge is a rising edge.
            s_d.cnt  = div;
            s_d.sclk = 1'b0;
        end else begin
            s_d.cnt  = tick ? '0 : s_q.cnt + 1'b1;
            s_d.sclk = ({1'b0, s_d.cnt} < half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk = s_q.sclk;

    // R3
    sclk_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(tick));

    // R7
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);
endmodule

// File: rtl/sport_lane.sv
module sport_lane #(
    parameter int WLONG  = 24,
    parameter int WSHORT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [WLONG-1:0] word,
    input  logic             start,
    input  logic             wide,
    input  logic             step,
    input  logic             clr,
    output logic             sdo
);
    localparam int PAD = WLONG - WSHORT;

    typedef struct packed {
        logic [WLONG-1:0] hold;
        logic [WLONG-1:0] sreg;
        logic             sdo;
    } lane_t;

    lane_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (cap) s_d.hold = word;
        if (clr) begin
            s_d.sdo = 1'b0;
        end else if (start) begin
            // A short word is left-aligned, so its MSB goes out first.
            s_d.sreg = wide ? s_q.hold : {s_q.hold[WSHORT-1:0], {PAD{1'b0}}};
            s_d.sdo  = 1'b0;
        end else if (step) begin
            s_d.sdo  = s_q.sreg[WLONG-1];
            s_d.sreg = {s_q.sreg[WLONG-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdo = s_q.sdo;

    // R6
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(step || start || clr)) |-> $stable(sdo));
endmodule

// File: rtl/dual_sport_tx.sv
module dual_sport_tx #(
    parameter int LANES  = 2,
    parameter int WLONG  = 24,
    parameter int WSHORT = 16,
    parameter int DIVW   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   master_en,
    input  logic [DIVW-1:0]        div_sel,
    input  logic                   wlen_sel,
    input  logic                   load,
    input  logic [LANES*WLONG-1:0] load_data,
    output logic                   sclk,
    output logic                   sdfs,
    output logic [LANES-1:0]       sdo,
    output logic                   overrun
);
    import dsport_pkg::*;

    localparam int BW = $clog2(WLONG);

    typedef struct packed {
        fr_state_e     st;
        logic          sdfs;
        logic [BW-1:0] bits;
        logic          wide;
        logic          pend;
        logic          ovr;
    } fr_t;

    fr_t  f_q, f_d;
    logic tick;
    logic consume, cap, start, step, clr;

    sport_sclk_div #(.DIVW(DIVW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (master_en),
        .div  (div_sel),
        .sclk (sclk),
        .tick (tick)
    );

    always_comb begin
        f_d     = f_q;
        consume = 1'b0;
        start   = 1'b0;
        step    = 1'b0;
        clr     = 1'b0;
        cap     = 1'b0;
        f_d.ovr = 1'b0;
        if (!master_en) begin
            f_d.st   = FR_IDLE;
            f_d.sdfs = 1'b0;
            f_d.pend = 1'b0;
            f_d.bits = '0;
            clr      = 1'b1;
        end else begin
            if (tick) begin
                unique case (f_q.st)
                    FR_IDLE: begin
                        if (f_q.pend) begin
                            start    = 1'b1;
                            consume  = 1'b1;
                            f_d.sdfs = 1'b1;
                            f_d.wide = wlen_sel;
                            f_d.st   = FR_SYNC;
                        end
                    end
                    FR_SYNC: begin
                        f_d.sdfs = 1'b0;
                        step     = 1'b1;
                        f_d.bits = f_q.wide ? BW'(WLONG-1) : BW'(WSHORT-1);
                        f_d.st   = FR_SHIFT;
                    end
                    FR_SHIFT: begin
                        if (f_q.bits != '0) begin
                            step     = 1'b1;
                            f_d.bits = f_q.bits - 1'b1;
                        end else if (f_q.pend) begin
                            start    = 1'b1;
                            consume  = 1'b1;
                            f_d.sdfs = 1'b1;
                            f_d.wide = wlen_sel;
                            f_d.st   = FR_SYNC;
                        end else begin
                            clr    = 1'b1;
                            f_d.st = FR_IDLE;
                        end
                    end
                    default: begin
                        clr      = 1'b1;
                        f_d.sdfs = 1'b0;
                        f_d.st   = FR_IDLE;
                    end
                endcase
            end
            cap      = load && (!f_q.pend || consume);
            f_d.pend = (f_q.pend && !consume) || cap;
            f_d.ovr  = load && f_q.pend && !consume;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q    <= '0;
            f_q.st <= FR_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sport_lane #(.WLONG(WLONG), .WSHORT(WSHORT)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .cap  (cap),
            .word (load_data[g*WLONG +: WLONG]),
            .start(start),
            .wide (wlen_sel),
            .step (step),
            .clr  (clr),
            .sdo  (sdo[g])
        );
    end

    assign sdfs    = f_q.sdfs;
    assign overrun = f_q.ovr;

    // R5
    sdfs_one_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdfs && tick) |=> !sdfs);

    // R6
    sdfs_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(master_en && !tick) |-> $stable(sdfs));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (!sdfs && sdo == '0 && !overrun));

    // R9
    overrun_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> f_q.pend);

    // R10
    idle_sdo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == FR_IDLE) |-> (sdo == '0));
endmodule

// File: tb/dual_sport_tx_bench.sv
`timescale 1ns/1ps
module dual_sport_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_en = 1'b0;
    logic [2:0]  tb_div = 3'd0;
    logic        tb_wl = 1'b1;
    logic        load = 1'b0;
    logic [47:0] data = '0;
    logic        sclk, sdfs, overrun;
    logic [1:0]  sdo;

    always #2 clk = ~clk;

    dual_sport_tx u_dual_sport_tx (
        .clk(clk), .rst_n(rst_n), .master_en(tb_en), .div_sel(tb_div),
        .wlen_sel(tb_wl), .load(load), .load_data(data),
        .sclk(sclk), .sdfs(sdfs), .sdo(sdo), .overrun(overrun)
    );

    int checks = 0;
    int errors = 0;

    // Receiver state, updated at each falling edge.
    int          rise_idx = 0, nfr = 0, starts = 0;
    logic [23:0] fr0 [16];
    logic [23:0] fr1 [16];
    int          fr_sfs [16];
    logic        collecting = 1'b0;
    int          nb = 0, wl_now = 16;
    logic [23:0] acc0, acc1;
    logic        sclk_p = 1'b0, sdfs_p = 1'b0, sdfs_at_rise = 1'b0;
    logic [1:0]  sdo_p = '0;
    int          cyc = 0, hi = 0, last_per = 0, last_hi = 0;
    int          chg_err = 0, idle_err = 0, sync_err = 0, ovr_cnt = 0;
    int          last_L = 0;

    always @(negedge clk) begin
        logic rise;
        if (!rst_n) begin
            sclk_p = 1'b0; sdfs_p = 1'b0; sdo_p = '0; collecting = 1'b0;
        end else begin
            rise = tb_en && ((tb_div == 3'd0) || (!sclk_p && sclk));
            if (overrun) ovr_cnt++;
            if (!tb_en) collecting = 1'b0;
            if (!rise && tb_en && (sdfs !== sdfs_p || sdo !== sdo_p)) chg_err++;
            if (rise) begin
                last_per = cyc; last_hi = hi; cyc = 1; hi = sclk ? 1 : 0;
                rise_idx++;
                if (sdfs) begin
                    if (sdfs_at_rise || collecting) sync_err++;
                    collecting = 1'b1; nb = 0; acc0 = '0; acc1 = '0;
                    wl_now = tb_wl ? 24 : 16;
                    if (nfr < 16) fr_sfs[nfr] = rise_idx;
                    starts++;
                end else if (collecting) begin
                    acc0 = {acc0[22:0], sdo[0]};
                    acc1 = {acc1[22:0], sdo[1]};
                    nb++;
                    if (nb == wl_now) begin
                        if (nfr < 16) begin fr0[nfr] = acc0; fr1[nfr] = acc1; end
                        nfr++;
                        collecting = 1'b0;
                    end
                end else if (sdo != 2'b00) begin
                    idle_err++;
                end
                sdfs_at_rise = sdfs;
            end else begin
                cyc++; if (sclk) hi++;
            end
            sdo_p = sdo; sdfs_p = sdfs; sclk_p = sclk;
        end
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [23:0] w0, input logic [23:0] w1);
        @(negedge clk); #1;
        load = 1'b1; data = {w1, w0};
        @(negedge clk); #1;
        load = 1'b0;
        last_L = rise_idx;
    endtask

    task automatic wait_cnt(input int target, input int limit, input logic use_starts);
        for (int k = 0; k < limit; k++) begin
            if ((use_starts ? starts : nfr) >= target) break;
            @(negedge clk);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // div, wide, lane0 word, lane1 word
    localparam logic [51:0] VEC [7] = '{
        {3'd0, 1'b1, 24'h800001, 24'h7FFFFE},
        {3'd1, 1'b0, 24'hABA5C3, 24'h12FFFF},
        {3'd2, 1'b1, 24'hC0FFEE, 24'h123456},
        {3'd4, 1'b0, 24'h008000, 24'hFF7FFF},
        {3'd6, 1'b1, 24'hFFFFFF, 24'h000000},
        {3'd7, 1'b0, 24'h00F00F, 24'h001234},
        {3'd3, 1'b1, 24'h5A5A5A, 24'hA5A5A5}
    };

    logic done = 1'b0;

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base, L, dis_bad;
        logic [23:0] e0, e1;
        idle_cycles(4);
        // R11: outputs during and just after reset
        chk(sclk == 0 && sdfs == 0 && sdo == 0 && overrun == 0, "R11 in reset",
            {sclk, sdfs, sdo, overrun}, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 0 && sdfs == 0 && sdo == 0 && overrun == 0, "R11 after reset",
            {sclk, sdfs, sdo, overrun}, 0);
        #1 tb_en = 1'b1;

        foreach (VEC[i]) begin
            @(negedge clk); #1;
            tb_div = VEC[i][51:49];
            tb_wl  = VEC[i][48];
            idle_cycles(24);
            base = nfr;
            do_load(VEC[i][47:24], VEC[i][23:0]);
            L = last_L;
            wait_cnt(base + 1, 600, 1'b0);
            e0 = tb_wl ? VEC[i][47:24] : {8'h00, VEC[i][39:24]};
            e1 = tb_wl ? VEC[i][23:0]  : {8'h00, VEC[i][15:0]};
            chk(nfr == base + 1, "R2 frame count", nfr, base + 1);
            chk(fr0[base] == e0, "R1/R2 lane0 word", fr0[base], e0);
            chk(fr1[base] == e1, "R1/R2 lane1 word", fr1[base], e1);
            chk(fr_sfs[base] == L + 1, "R4 sync latency", fr_sfs[base], L + 1);
            if (tb_div == 3'd0) begin
                chk(sclk == 1'b1, "R3 ratio one held high", sclk, 1);
            end else begin
                chk(last_per == tb_div + 1, "R3 period", last_per, tb_div + 1);
                chk(last_hi == (tb_div + 2) / 2, "R3 high time", last_hi, (tb_div + 2) / 2);
            end
        end

        // R8 / R9: queued frame, then a dropped third load
        @(negedge clk); #1;
        tb_div = 3'd2; tb_wl = 1'b1;
        idle_cycles(12);
        base = nfr;
        L = ovr_cnt;
        do_load(24'h111111, 24'h222222);
        wait_cnt(starts + 1, 100, 1'b1);
        idle_cycles(3);
        do_load(24'h333333, 24'h444444);
        do_load(24'h555555, 24'h666666);
        wait_cnt(base + 2, 400, 1'b0);
        chk(ovr_cnt - L == 1, "R9 overrun pulses", ovr_cnt - L, 1);
        chk(fr0[base + 1] == 24'h333333, "R8 queued lane0", fr0[base + 1], 24'h333333);
        chk(fr1[base + 1] == 24'h444444, "R8 queued lane1", fr1[base + 1], 24'h444444);
        chk(fr_sfs[base + 1] - fr_sfs[base] == 25, "R8 back-to-back spacing",
            fr_sfs[base + 1] - fr_sfs[base], 25);
        idle_cycles(200);
        chk(nfr == base + 2, "R9 dropped load sends nothing", nfr, base + 2);

        // R7: abandon a running frame, then ignore loads while disabled
        do_load(24'h0F0F0F, 24'hF0F0F0);
        wait_cnt(starts + 1, 100, 1'b1);
        idle_cycles(6);
        base = nfr;
        #1 tb_en = 1'b0;
        @(negedge clk);
        chk(sclk == 0 && sdfs == 0 && sdo == 0, "R7 abort outputs low",
            {sclk, sdfs, sdo}, 0);
        do_load(24'hABCDEF, 24'h123456);
        dis_bad = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (sclk || sdfs || sdo != 0) dis_bad++;
        end
        chk(dis_bad == 0, "R7 quiet while disabled", dis_bad, 0);
        #1 tb_en = 1'b1;
        idle_cycles(150);
        chk(nfr == base, "R7 disabled load discarded", nfr, base);

        chk(sync_err == 0, "R5 sync width and order", sync_err, 0);
        chk(chg_err == 0, "R6 changes only on rising sclk", chg_err, 0);
        chk(idle_err == 0, "R10 idle data low", idle_err, 0);
        chk(last_per == tb_div + 1, "R10 sclk runs while idle", last_per, tb_div + 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule